// File: doc/BRIEF.md
# NAND Flash Target Responder

This block stands in for a byte-wide NAND flash device so that a flash controller can be exercised against it in simulation. A controller drives chip enable, write enable, read enable and two latch-steering lines (one marking a command byte, one marking an address byte) together with a byte of data. The responder decodes that traffic, keeps a one-page data buffer and a small array of blocks made of pages, and reports progress on a ready/busy line that is high when idle. The byte bus is split into an input byte, an output byte and an output-enable, so a wrapper can build the tri-state pad. All pins are sampled on the system clock; a strobe edge is seen one clock after the pin moves.

Four operations are recognised. A page read moves a page into the buffer during a busy period and then streams it out from a chosen column. A program loads the buffer with bytes and then merges it into a page, which can only clear bits. A block erase sets every byte of one block to 0xFF. A status query returns a byte that carries readiness and the outcome of the last program. The page size, pages per block, block count, row-address byte count and the three busy durations are parameters, scaled down by default so the whole array stays small.

Top module: `nand_flash_responder`

## Requirements
- R1: While ceN is high, edges on weN and reN have no effect and ioOe stays low.
- R2: A byte captured with cle=1, ale=0 is a command; with cle=0, ale=1 an address byte; with both low a data byte; with both high it is discarded.
- R3: Bytes are captured when weN rises; while reN is low with ceN low and an output mode active, ioOe is high and ioOut shows the current byte; in data mode each rise of reN advances the column, wrapping from PAGE_BYTES-1 to 0.
- R4: A read or program address is one column byte followed by ROW_BYTES row bytes, low byte first; the low 5 bits of the row select the page within the block and the remaining row bits (modulo NUM_BLOCKS) select the block.
- R5: Command 0x00 followed by the full address holds rbN low for exactly READ_BUSY cycles, after which the selected page is read out starting at the given column.
- R6: Command 0x80 presets the page buffer to 0xFF; after the address, data bytes fill the buffer from the column upward; command 0x10 holds rbN low for exactly PROG_BUSY cycles and leaves each stored byte equal to its old value AND the buffer byte.
- R7: Command 0x60, ROW_BYTES row bytes and command 0xD0 hold rbN low for exactly ERASE_BUSY cycles and set every byte of the addressed block to 0xFF; the page bits of the row are ignored and other blocks keep their content.
- R8: Command 0x70, accepted even while busy, selects status output: bit 6 is 1 when ready, bit 0 is the fail flag, all other bits 0.
- R9: The fail flag is set by a program whose buffer asked any stored 0 bit to become 1, cleared by a program that did not, and cleared by an erase.
- R10: While rbN is low, every command other than 0x70, every address byte and every data byte is ignored.
- R11: After reset rbN is high, ioOe is low, the fail flag is clear and every stored byte is 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write strobe, byte captured on its rise |
| reN | input | 1 | Read strobe, output driven while low |
| cle | input | 1 | Marks the captured byte as a command |
| ale | input | 1 | Marks the captured byte as an address |
| ioIn | input | 8 | Byte from the controller |
| ioOut | output | 8 | Byte to the controller |
| ioOe | output | 1 | Enables the output byte onto the shared bus |
| rbN | output | 1 | Ready (1) or busy (0) |

## Verification
The bound checker watches the pin-level rules on every cycle: the bus is released whenever chip enable is high or read enable is high, a busy period only begins right after a captured command or address byte, a byte captured with both latch lines high never starts one, no busy period outlasts the longest configured duration, and anything driven during busy is a status byte showing not-ready. What only the directed scenarios can show is the stored content: the AND merge of programming, the reach of an erase to exactly one block, column wrap-around, the exact busy lengths, the fail flag and the commands dropped while busy or deselected.

// File: rtl/nand_resp_pkg.sv
package nand_resp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_ADDR, ST_PG_ADDR, ST_PG_DATA,
    ST_ER_ADDR, ST_BUSY_RD, ST_BUSY_PG, ST_BUSY_ER
  } seqState_t;

  typedef enum logic [1:0] {OUT_NONE, OUT_DATA, OUT_STATUS} outMode_t;

  // Strobes from the sequencer to the storage datapath
  typedef struct packed {
    logic       colLoad;
    logic       colStep;
    logic       rowLoad;
    logic [2:0] rowSel;
    logic       pageFill;
    logic       pageWrite;
    logic       pageLoad;
    logic       pageCommit;
    logic       blockErase;
  } dpStrobe_t;

  localparam logic [7:0] CMD_READ       = 8'h00;
  localparam logic [7:0] CMD_PROG       = 8'h80;
  localparam logic [7:0] CMD_PROG_GO    = 8'h10;
  localparam logic [7:0] CMD_ERASE      = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO   = 8'hD0;
  localparam logic [7:0] CMD_STATUS     = 8'h70;

endpackage

// File: rtl/nand_resp_ctrl.sv
module nand_resp_ctrl
  import nand_resp_pkg::*;
#(
  parameter int ROW_BYTES  = 2,
  parameter int READ_BUSY  = 8,
  parameter int PROG_BUSY  = 20,
  parameter int ERASE_BUSY = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       weN,
  input  logic       reN,
  input  logic       cle,
  input  logic       ale,
  input  logic [7:0] ioIn,
  output dpStrobe_t  strb,
  output outMode_t   outMode,
  output logic       busy
);
  localparam int MAX_BUSY = (READ_BUSY > PROG_BUSY)
                            ? ((READ_BUSY > ERASE_BUSY) ? READ_BUSY : ERASE_BUSY)
                            : ((PROG_BUSY > ERASE_BUSY) ? PROG_BUSY : ERASE_BUSY);
  localparam int CNT_W  = $clog2(MAX_BUSY + 1);
  localparam int AIDX_W = $clog2(ROW_BYTES + 2);

  seqState_t         state;
  logic [AIDX_W-1:0] addrIdx;
  logic [CNT_W-1:0]  cnt;
  logic              weQ, reQ;

  logic weRise, reRise, isCmd, isAddr, isData, lastAddr, done;

  assign weRise   = !ceN && weN && !weQ;
  assign reRise   = !ceN && reN && !reQ;
  assign isCmd    = weRise && cle && !ale;
  assign isAddr   = weRise && ale && !cle;
  assign isData   = weRise && !cle && !ale;
  assign lastAddr = (addrIdx == AIDX_W'(ROW_BYTES));
  assign busy     = (state == ST_BUSY_RD) || (state == ST_BUSY_PG) || (state == ST_BUSY_ER);
  assign done     = busy && (cnt == '0);

  always_comb begin
    strb = '0;
    if (isAddr) begin
      if (state == ST_RD_ADDR || state == ST_PG_ADDR) begin
        if (addrIdx == '0) strb.colLoad = 1'b1;
        else begin
          strb.rowLoad = 1'b1;
          strb.rowSel  = 3'(addrIdx - AIDX_W'(1));
        end
      end else if (state == ST_ER_ADDR && !lastAddr) begin
        strb.rowLoad = 1'b1;
        strb.rowSel  = 3'(addrIdx);
      end
    end
    if (isData && state == ST_PG_DATA)          strb.pageWrite = 1'b1;
    if (reRise && outMode == OUT_DATA)          strb.colStep   = 1'b1;
    if (isCmd && !busy && ioIn == CMD_PROG)     strb.pageFill  = 1'b1;
    if (done && state == ST_BUSY_RD)            strb.pageLoad  = 1'b1;
    if (done && state == ST_BUSY_PG)            strb.pageCommit = 1'b1;
    if (done && state == ST_BUSY_ER)            strb.blockErase = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      addrIdx <= '0;
      cnt     <= '0;
      outMode <= OUT_NONE;
      weQ     <= 1'b1;
      reQ     <= 1'b1;
    end else begin
      weQ <= weN;
      reQ <= reN;
      if (done) begin
        state <= ST_IDLE;
        if (state == ST_BUSY_RD) outMode <= OUT_DATA;
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
        if (isCmd && ioIn == CMD_STATUS) outMode <= OUT_STATUS;
      end else begin
        if (isCmd) begin
          case (ioIn)
            CMD_READ:   begin state <= ST_RD_ADDR; addrIdx <= '0; outMode <= OUT_NONE; end
            CMD_PROG:   begin state <= ST_PG_ADDR; addrIdx <= '0; outMode <= OUT_NONE; end
            CMD_ERASE:  begin state <= ST_ER_ADDR; addrIdx <= '0; outMode <= OUT_NONE; end
            CMD_STATUS: outMode <= OUT_STATUS;
            CMD_PROG_GO: if (state == ST_PG_DATA) begin
              state <= ST_BUSY_PG;
              cnt   <= CNT_W'(PROG_BUSY - 1);
            end
            CMD_ERASE_GO: if (state == ST_ER_ADDR && lastAddr) begin
              state <= ST_BUSY_ER;
              cnt   <= CNT_W'(ERASE_BUSY - 1);
            end
            default: ;
          endcase
        end
        if (isAddr) begin
          case (state)
            ST_RD_ADDR: begin
              addrIdx <= addrIdx + AIDX_W'(1);
              if (lastAddr) begin
                state <= ST_BUSY_RD;
                cnt   <= CNT_W'(READ_BUSY - 1);
              end
            end
            ST_PG_ADDR: begin
              addrIdx <= addrIdx + AIDX_W'(1);
              if (lastAddr) state <= ST_PG_DATA;
            end
            ST_ER_ADDR: if (!lastAddr) addrIdx <= addrIdx + AIDX_W'(1);
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/nand_resp_dp.sv
module nand_resp_dp
  import nand_resp_pkg::*;
#(
  parameter int PAGE_BYTES      = 16,
  parameter int PAGES_PER_BLOCK = 32,
  parameter int NUM_BLOCKS      = 4,
  parameter int ROW_BYTES       = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strb,
  input  outMode_t   outMode,
  input  logic       ready,
  input  logic       ceN,
  input  logic       reN,
  input  logic [7:0] ioIn,
  output logic [7:0] ioOut,
  output logic       ioOe
);
  localparam int COL_W       = $clog2(PAGE_BYTES);
  localparam int PG_W        = $clog2(PAGES_PER_BLOCK);
  localparam int BLK_W       = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  localparam int ROW_W       = 8 * ROW_BYTES;
  localparam int BLOCK_BYTES = PAGES_PER_BLOCK * PAGE_BYTES;
  localparam int TOTAL       = NUM_BLOCKS * BLOCK_BYTES;
  localparam int ADDR_W      = $clog2(TOTAL);

  logic [7:0]        mem     [TOTAL];
  logic [7:0]        pageReg [PAGE_BYTES];
  logic [COL_W-1:0]  colPtr, colNext, colIn;
  logic [ROW_W-1:0]  rowReg;
  logic [BLK_W-1:0]  blkSel;
  logic [PG_W-1:0]   pgSel;
  logic [ADDR_W-1:0] blkBase, pageBase;
  logic              failQ, violation;

  assign pgSel    = rowReg[PG_W-1:0];
  assign blkSel   = BLK_W'(rowReg[ROW_W-1:PG_W] % (ROW_W-PG_W)'(NUM_BLOCKS));
  assign blkBase  = ADDR_W'(blkSel) * ADDR_W'(BLOCK_BYTES);
  assign pageBase = blkBase + ADDR_W'(pgSel) * ADDR_W'(PAGE_BYTES);
  assign colNext  = (colPtr == COL_W'(PAGE_BYTES - 1)) ? '0 : colPtr + COL_W'(1);
  assign colIn    = (ioIn < 8'(PAGE_BYTES)) ? COL_W'(ioIn) : '0;

  // Any buffer 1 over a stored 0 is a bit the program cannot set
  always_comb begin
    violation = 1'b0;
    for (int i = 0; i < PAGE_BYTES; i++)
      violation = violation | (|(pageReg[i] & ~mem[pageBase + ADDR_W'(i)]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TOTAL; i++)      mem[i]     <= 8'hFF;
      for (int i = 0; i < PAGE_BYTES; i++) pageReg[i] <= 8'hFF;
      colPtr <= '0;
      rowReg <= '0;
      failQ  <= 1'b0;
    end else begin
      if (strb.colLoad) colPtr <= colIn;
      else if (strb.pageWrite || strb.colStep) colPtr <= colNext;
      if (strb.rowLoad) rowReg[8*int'(strb.rowSel) +: 8] <= ioIn;
      if (strb.pageFill)
        for (int i = 0; i < PAGE_BYTES; i++) pageReg[i] <= 8'hFF;
      if (strb.pageWrite) pageReg[colPtr] <= ioIn;
      if (strb.pageLoad)
        for (int i = 0; i < PAGE_BYTES; i++) pageReg[i] <= mem[pageBase + ADDR_W'(i)];
      if (strb.pageCommit) begin
        for (int i = 0; i < PAGE_BYTES; i++)
          mem[pageBase + ADDR_W'(i)] <= mem[pageBase + ADDR_W'(i)] & pageReg[i];
        failQ <= violation;
      end
      if (strb.blockErase) begin
        for (int j = 0; j < BLOCK_BYTES; j++) mem[blkBase + ADDR_W'(j)] <= 8'hFF;
        failQ <= 1'b0;
      end
    end
  end

  assign ioOe  = !ceN && !reN && (outMode != OUT_NONE);
  assign ioOut = (outMode == OUT_STATUS) ? {1'b0, ready, 5'b0, failQ} : pageReg[colPtr];

endmodule

// File: rtl/nand_flash_responder.sv
module nand_flash_responder
  import nand_resp_pkg::*;
#(
  parameter int PAGE_BYTES      = 16,
  parameter int PAGES_PER_BLOCK = 32,
  parameter int NUM_BLOCKS      = 4,
  parameter int ROW_BYTES       = 2,
  parameter int READ_BUSY       = 8,
  parameter int PROG_BUSY       = 20,
  parameter int ERASE_BUSY      = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       weN,
  input  logic       reN,
  input  logic       cle,
  input  logic       ale,
  input  logic [7:0] ioIn,
  output logic [7:0] ioOut,
  output logic       ioOe,
  output logic       rbN
);
  dpStrobe_t strb;
  outMode_t  outMode;
  logic      busy;

  nand_resp_ctrl #(
    .ROW_BYTES(ROW_BYTES), .READ_BUSY(READ_BUSY),
    .PROG_BUSY(PROG_BUSY), .ERASE_BUSY(ERASE_BUSY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .reN(reN),
    .cle(cle), .ale(ale), .ioIn(ioIn),
    .strb(strb), .outMode(outMode), .busy(busy)
  );

  nand_resp_dp #(
    .PAGE_BYTES(PAGE_BYTES), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
    .NUM_BLOCKS(NUM_BLOCKS), .ROW_BYTES(ROW_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .outMode(outMode), .ready(!busy),
    .ceN(ceN), .reN(reN), .ioIn(ioIn), .ioOut(ioOut), .ioOe(ioOe)
  );

  assign rbN = !busy;

endmodule

// File: rtl/nand_flash_responder_chk.sv
module nand_flash_responder_chk #(
  parameter int READ_BUSY  = 8,
  parameter int PROG_BUSY  = 20,
  parameter int ERASE_BUSY = 40
) (
  input logic       clk,
  input logic       rstN,
  input logic       ceN,
  input logic       weN,
  input logic       reN,
  input logic       cle,
  input logic       ale,
  input logic [7:0] ioOut,
  input logic       ioOe,
  input logic       rbN
);
  localparam int MAX_BUSY = (READ_BUSY > PROG_BUSY)
                            ? ((READ_BUSY > ERASE_BUSY) ? READ_BUSY : ERASE_BUSY)
                            : ((PROG_BUSY > ERASE_BUSY) ? PROG_BUSY : ERASE_BUSY);

  logic [31:0] busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (!rbN) busyRun <= busyRun + 32'd1;
    else           busyRun <= '0;
  end

  p_ce_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> !ioOe);

  p_drive_under_re_r3: assert property (@(posedge clk) disable iff (!rstN)
    ioOe |-> !reN);

  p_busy_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rbN) |-> ($past(weN) && !$past(ceN) && ($past(cle) != $past(ale))));

  p_undef_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && cle && ale && weN && !$past(weN) && rbN) |=> rbN);

  p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= 32'(MAX_BUSY));

  p_busy_status_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ioOe && !rbN) |-> (ioOut[7:1] == 7'b0));

endmodule

bind nand_flash_responder nand_flash_responder_chk #(
  .READ_BUSY(READ_BUSY), .PROG_BUSY(PROG_BUSY), .ERASE_BUSY(ERASE_BUSY)
) u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .reN(reN),
  .cle(cle), .ale(ale), .ioOut(ioOut), .ioOe(ioOe), .rbN(rbN)
);

// File: tb/nand_flash_responder_bench.sv
module nand_flash_responder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int READ_BUSY  = 8;
  localparam int PROG_BUSY  = 20;
  localparam int ERASE_BUSY = 40;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ceN = 1'b0, weN = 1'b1, reN = 1'b1, cle = 1'b0, ale = 1'b0;
  logic [7:0] ioIn = 8'h00;
  logic [7:0] ioOut;
  logic       ioOe, rbN;
  int         checkCount = 0;
  int         failCount  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_flash_responder #(
    .PAGE_BYTES(16), .PAGES_PER_BLOCK(32), .NUM_BLOCKS(4), .ROW_BYTES(2),
    .READ_BUSY(READ_BUSY), .PROG_BUSY(PROG_BUSY), .ERASE_BUSY(ERASE_BUSY)
  ) u_nand_flash_responder (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .reN(reN),
    .cle(cle), .ale(ale), .ioIn(ioIn), .ioOut(ioOut), .ioOe(ioOe), .rbN(rbN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk); cle = c; ale = a; ioIn = d; weN = 1'b0;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0;
  endtask

  task automatic readExpect(input logic [7:0] exp, input string req);
    @(negedge clk); reN = 1'b0;
    #1;
    check(ioOe === 1'b1 && ioOut === exp, req, {ioOe, ioOut}, {1'b1, exp});
    @(negedge clk); reN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitReady(input int expLen, input string req);
    int n = 0;
    while (!rbN && n < 1000) begin n++; @(negedge clk); end
    if (expLen >= 0) check(n == expLen, req, n, expLen);
  endtask

  task automatic pageRead(input logic [7:0] row0, input logic [7:0] col);
    busWrite(1, 0, 8'h00);
    busWrite(0, 1, col); busWrite(0, 1, row0); busWrite(0, 1, 8'h00);
    waitReady(READ_BUSY, "R5 read busy length");
  endtask

  task automatic pageProgram(input logic [7:0] row0, input logic [7:0] col,
                             input logic [7:0] d0, input logic [7:0] d1);
    busWrite(1, 0, 8'h80);
    busWrite(0, 1, col); busWrite(0, 1, row0); busWrite(0, 1, 8'h00);
    busWrite(0, 0, d0); busWrite(0, 0, d1);
    busWrite(1, 0, 8'h10);
    waitReady(PROG_BUSY, "R6 program busy length");
  endtask

  task automatic statusExpect(input logic [7:0] exp, input string req);
    busWrite(1, 0, 8'h70);
    readExpect(exp, req);
  endtask

  task automatic testReset;
    check(rbN === 1'b1, "R11 ready after reset", rbN, 1);
    check(ioOe === 1'b0, "R11 bus released after reset", ioOe, 0);
    statusExpect(8'h40, "R11 R8 status after reset");
    pageRead(8'h05, 8'h00);
    readExpect(8'hFF, "R11 erased content");
    readExpect(8'hFF, "R11 erased content next column");
  endtask

  task automatic testProgram;
    pageProgram(8'h23, 8'h02, 8'hA5, 8'h3C);
    statusExpect(8'h40, "R9 program pass status");
    pageRead(8'h23, 8'h00);
    readExpect(8'hFF, "R6 untouched column 0");
    readExpect(8'hFF, "R6 untouched column 1");
    readExpect(8'hA5, "R6 programmed column 2");
    readExpect(8'h3C, "R6 programmed column 3");
    readExpect(8'hFF, "R3 R6 untouched column 4");
  endtask

  task automatic testPageSelect;
    pageRead(8'h24, 8'h02);
    readExpect(8'hFF, "R4 neighbouring page untouched");
    pageRead(8'h03, 8'h02);
    readExpect(8'hFF, "R4 same page other block untouched");
  endtask

  task automatic testAndMerge;
    pageProgram(8'h23, 8'h02, 8'hFF, 8'h0F);
    statusExpect(8'h41, "R9 fail flag on 0-to-1 request");
    pageRead(8'h23, 8'h02);
    readExpect(8'hA5, "R6 AND merge keeps old byte");
    readExpect(8'h0C, "R6 AND merge clears bits");
  endtask

  task automatic testWrap;
    pageProgram(8'h40, 8'h0F, 8'h11, 8'h22);
    pageRead(8'h40, 8'h0F);
    readExpect(8'h11, "R3 last column");
    readExpect(8'h22, "R3 column wraps to 0");
  endtask

  task automatic testErase;
    busWrite(1, 0, 8'h60);
    busWrite(0, 1, 8'h23); busWrite(0, 1, 8'h00);
    busWrite(1, 0, 8'hD0);
    waitReady(ERASE_BUSY, "R7 erase busy length");
    statusExpect(8'h40, "R9 erase clears fail flag");
    pageRead(8'h23, 8'h02);
    readExpect(8'hFF, "R7 erased block reads 0xFF");
    pageRead(8'h40, 8'h0F);
    readExpect(8'h11, "R7 other block kept");
  endtask

  task automatic testBusyCommands;
    busWrite(1, 0, 8'h60);
    busWrite(0, 1, 8'h60); busWrite(0, 1, 8'h00);
    busWrite(1, 0, 8'hD0);
    check(rbN === 1'b0, "R7 busy after erase confirm", rbN, 0);
    statusExpect(8'h00, "R8 status while busy");
    busWrite(1, 0, 8'h80);
    busWrite(0, 1, 8'h00);
    waitReady(-1, "R10");
    readExpect(8'h40, "R10 commands during busy ignored");
  endtask

  task automatic testChipDisable;
    ceN = 1'b1;
    busWrite(1, 0, 8'h00);
    busWrite(0, 1, 8'h00); busWrite(0, 1, 8'h00); busWrite(0, 1, 8'h00);
    check(rbN === 1'b1, "R1 no busy while deselected", rbN, 1);
    @(negedge clk); reN = 1'b0; #1;
    check(ioOe === 1'b0, "R1 bus released while deselected", ioOe, 0);
    @(negedge clk); reN = 1'b1;
    ceN = 1'b0;
    readExpect(8'h40, "R1 mode unchanged by deselected strobes");
  endtask

  task automatic testUndefined;
    busWrite(1, 1, 8'h00);
    check(rbN === 1'b1, "R2 both latch lines high ignored", rbN, 1);
    readExpect(8'h40, "R2 mode unchanged by undefined byte");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testProgram();
    testPageSelect();
    testAndMerge();
    testWrap();
    testErase();
    testBusyCommands();
    testChipDisable();
    testUndefined();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule